// File: doc/BRIEF.md
# Supply Hiccup and Fault Supervisor

This block is the sequencing brain of an offline switching controller. It sees the supply rail only through five digitized comparator flags and two digitized pin flags: feedback open and the external latch pin high. From these it decides three things. It decides when the high-voltage startup source charges the supply, and whether that source uses its low or high current. It decides when the gate drive may switch. It raises a one-cycle soft-start request at every launch of switching.

At power-up the supervisor charges the rail until the turn-on comparator trips, then hands over to switching. Two conditions count as a fault while switching: feedback held open for a full fault window, or the rail sagging under the turn-off level. On a fault it stops the drive and runs a double hiccup. The rail is allowed to sink to the hiccup-low level and is then recharged to the turn-on level, twice, before a restart is attempted with a fresh soft start. A filtered external latch request overrides everything else. It parks the block in latched shutdown, where the rail keeps cycling between hiccup-low and turn-on with the drive held off. This state is left only when the rail collapses below the reset level, which hiccup alone never reaches.

States: `ST_CHARGE` (initial charge), `ST_LAUNCH` (first switching cycle, soft-start request), `ST_RUN` (switching), `ST_HIC_DRAIN` / `ST_HIC_REFILL` (fault hiccup discharge and recharge), `ST_LAT_DRAIN` / `ST_LAT_REFILL` (latched discharge and recharge). Transitions: CHARGE→LAUNCH on turn-on; LAUNCH→RUN unconditionally when no fault or latch request is present; LAUNCH/RUN→HIC_DRAIN on fault; HIC_DRAIN→HIC_REFILL on hiccup-low; HIC_REFILL→HIC_DRAIN on turn-on before the last round, →LAUNCH after it; any non-latched state→LAT_DRAIN on a filtered latch request; LAT_DRAIN↔LAT_REFILL on hiccup-low / turn-on; either latched state→CHARGE on the reset level.

Top module: `hiccup_supervisor`

## Requirements
- R1: After reset the block is in the initial charge state, with `hv_src_en`=1, `drive_en`=0 and `softstart_req`=0. The startup source and the drive are never enabled in the same cycle.
- R2: `hv_src_hi` is 1 only while the source is enabled and `vcc_below_inh`=0. While the source is enabled with `vcc_below_inh`=1 it is 0.
- R3: In the charge state, `vcc_above_on`=1 sampled at an edge moves the block to launch. Launch lasts exactly one cycle with `drive_en`=1, `softstart_req`=1 and the source off. Switching then continues in the run state with `softstart_req`=0.
- R4: Feedback open is timed only while the drive is enabled. It becomes a fault after FB_OPEN_US worth of consecutive clock samples, and `drive_en` falls on the following edge. Any sample with `fb_open`=0 restarts the count from zero.
- R5: `vcc_below_off`=1 sampled while the drive is enabled is a fault, and `drive_en` is 0 from the next edge.
- R6: In a fault the drive stays off. The source stays off until `vcc_below_low`=1 and is then on until `vcc_above_on`=1. After HICCUP_ROUNDS such recharges (default 2) the block relaunches with a soft-start request. After fewer recharges it discharges again.
- R7: `latch_pin` must be high for LATCH_FILT_NS worth of consecutive samples. The block then enters latched shutdown on the next edge. Shorter pulses have no effect. The latch request wins over a feedback or undervoltage fault seen at the same edge, and it acts from every non-latched state.
- R8: In latched shutdown `drive_en` and `softstart_req` stay 0 indefinitely. The source turns on at `vcc_below_low`=1 and off at `vcc_above_on`=1, for any number of rounds.
- R9: Latched shutdown is cleared only by `vcc_below_rst`=1, which returns the block to the charge state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Supply at or above the turn-on level |
| vcc_below_off | input | 1 | Supply below the turn-off level |
| vcc_below_low | input | 1 | Supply below the hiccup-low level |
| vcc_below_rst | input | 1 | Supply below the latch reset level |
| vcc_below_inh | input | 1 | Supply below the startup inhibit level |
| fb_open | input | 1 | Feedback pin open (no regulation signal) |
| latch_pin | input | 1 | External latch pin above its threshold |
| hv_src_en | output | 1 | Startup current source enable |
| hv_src_hi | output | 1 | Startup source high-current select |
| drive_en | output | 1 | Gate drive switching enable |
| softstart_req | output | 1 | One-cycle soft-start request at each launch |

## Verification
Several rules are checked by assertion on every clock: the source and the drive are mutually exclusive; the low-current setting is forced below the inhibit level; any rising drive enable is accompanied by a soft-start request that lasts one cycle; an undervoltage seen while switching stops the drive next cycle; and a latch pin held for the whole filter window removes the drive next cycle. Counting rules that span many cycles can only be shown by the bench scenarios. These include the exact end of the feedback window and its reset by a short recovery, the number of hiccup rounds before a relaunch, latched shutdown persisting through repeated rail cycles, and release only at the reset level.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_CHARGE     = 3'd0,
        ST_LAUNCH     = 3'd1,
        ST_RUN        = 3'd2,
        ST_HIC_DRAIN  = 3'd3,
        ST_HIC_REFILL = 3'd4,
        ST_LAT_DRAIN  = 3'd5,
        ST_LAT_REFILL = 3'd6
    } sup_state_t;

    // Converts a duration in nanoseconds to clock cycles, at least one.
    function automatic int unsigned ns_to_cycles(input longint unsigned clk_khz,
                                                 input longint unsigned dur_ns);
        longint unsigned c;
        c = (clk_khz * dur_ns) / 64'd1_000_000;
        if (c < 64'd1) c = 64'd1;
        return int'(c);
    endfunction

endpackage

// File: rtl/persist_timer.sv
// Counts consecutive high samples of a level; hit is set once LIMIT
// samples in a row have been seen and stays set while the level holds.
module persist_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!level) begin
            run_q <= '0;
        end else if (run_q != CMAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = (run_q == CMAX);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
#(
    parameter int unsigned HICCUP_ROUNDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on,
    input  logic below_off,
    input  logic below_low,
    input  logic below_rst,
    input  logic below_inh,
    input  logic fb_fault,
    input  logic latch_hit,
    output logic src_en,
    output logic src_hi,
    output logic drv_en,
    output logic ss_req,
    output logic fb_watch
);
    localparam int unsigned RW = (HICCUP_ROUNDS > 1) ? $clog2(HICCUP_ROUNDS) : 1;
    localparam logic [RW-1:0] LAST_ROUND = RW'(HICCUP_ROUNDS - 1);

    sup_state_t st_q, st_d;
    logic [RW-1:0] rnd_q, rnd_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CHARGE;
            rnd_q <= '0;
        end else begin
            st_q  <= st_d;
            rnd_q <= rnd_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        rnd_d = rnd_q;
        unique case (st_q)
            ST_CHARGE: begin
                if (latch_hit)     st_d = ST_LAT_DRAIN;
                else if (above_on) st_d = ST_LAUNCH;
            end
            ST_LAUNCH, ST_RUN: begin
                if (latch_hit) begin
                    st_d = ST_LAT_DRAIN;
                end else if (fb_fault || below_off) begin
                    st_d  = ST_HIC_DRAIN;
                    rnd_d = '0;
                end else begin
                    st_d = ST_RUN;
                end
            end
            ST_HIC_DRAIN: begin
                if (latch_hit)      st_d = ST_LAT_DRAIN;
                else if (below_low) st_d = ST_HIC_REFILL;
            end
            ST_HIC_REFILL: begin
                if (latch_hit) begin
                    st_d = ST_LAT_DRAIN;
                end else if (above_on) begin
                    if (rnd_q == LAST_ROUND) begin
                        st_d  = ST_LAUNCH;
                        rnd_d = '0;
                    end else begin
                        st_d  = ST_HIC_DRAIN;
                        rnd_d = rnd_q + 1'b1;
                    end
                end
            end
            ST_LAT_DRAIN: begin
                if (below_rst)      st_d = ST_CHARGE;
                else if (below_low) st_d = ST_LAT_REFILL;
            end
            ST_LAT_REFILL: begin
                if (below_rst)     st_d = ST_CHARGE;
                else if (above_on) st_d = ST_LAT_DRAIN;
            end
            default: st_d = ST_CHARGE;
        endcase
    end

    // Output logic
    always_comb begin
        src_en = 1'b0;
        drv_en = 1'b0;
        ss_req = 1'b0;
        unique case (st_q)
            ST_CHARGE, ST_HIC_REFILL, ST_LAT_REFILL: src_en = 1'b1;
            ST_LAUNCH: begin
                drv_en = 1'b1;
                ss_req = 1'b1;
            end
            ST_RUN: drv_en = 1'b1;
            default: ;
        endcase
        src_hi   = src_en && !below_inh;
        fb_watch = drv_en;
    end
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 125_000,
    parameter int unsigned FB_OPEN_US    = 130_000,
    parameter int unsigned LATCH_FILT_NS = 13_000,
    parameter int unsigned HICCUP_ROUNDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_on,
    input  logic vcc_below_off,
    input  logic vcc_below_low,
    input  logic vcc_below_rst,
    input  logic vcc_below_inh,
    input  logic fb_open,
    input  logic latch_pin,
    output logic hv_src_en,
    output logic hv_src_hi,
    output logic drive_en,
    output logic softstart_req
);
    localparam int unsigned FB_CYC    = ns_to_cycles(longint'(CLK_KHZ),
                                                     longint'(FB_OPEN_US) * 64'd1000);
    localparam int unsigned LATCH_CYC = ns_to_cycles(longint'(CLK_KHZ),
                                                     longint'(LATCH_FILT_NS));

    logic fb_watch;
    logic fb_fault;
    logic latch_hit;

    persist_timer #(.LIMIT(FB_CYC)) u_fb_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fb_open && fb_watch),
        .hit   (fb_fault)
    );

    persist_timer #(.LIMIT(LATCH_CYC)) u_latch_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .level (latch_pin),
        .hit   (latch_hit)
    );

    sup_fsm #(.HICCUP_ROUNDS(HICCUP_ROUNDS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_on  (vcc_above_on),
        .below_off (vcc_below_off),
        .below_low (vcc_below_low),
        .below_rst (vcc_below_rst),
        .below_inh (vcc_below_inh),
        .fb_fault  (fb_fault),
        .latch_hit (latch_hit),
        .src_en    (hv_src_en),
        .src_hi    (hv_src_hi),
        .drv_en    (drive_en),
        .ss_req    (softstart_req),
        .fb_watch  (fb_watch)
    );
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned LATCH_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic vcc_below_off,
    input logic vcc_below_inh,
    input logic latch_pin,
    input logic hv_src_en,
    input logic hv_src_hi,
    input logic drive_en,
    input logic softstart_req
);
    localparam int unsigned CW = $clog2(LATCH_CYC + 1);

    // Independent count of consecutive latch-pin samples.
    logic [CW-1:0] lp_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lp_run <= '0;
        else if (!latch_pin)            lp_run <= '0;
        else if (lp_run != CW'(LATCH_CYC)) lp_run <= lp_run + 1'b1;
    end

    // R1: source and drive never on together
    a_r1_src_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_src_en && drive_en));

    // R2: low-current setting below the inhibit level
    a_r2_inhibit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_src_en && vcc_below_inh) |-> !hv_src_hi);

    // R3: every drive start comes with a soft-start request
    a_r3_launch_ss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> softstart_req);

    // R3: soft-start request lasts a single cycle
    a_r3_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_req |=> !softstart_req);

    // R5: undervoltage while switching stops the drive
    a_r5_uv_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && vcc_below_off) |=> !drive_en);

    // R7: latch pin held through the filter window stops the drive
    a_r7_latch_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_run == CW'(LATCH_CYC)) |=> !drive_en);
endmodule

bind hiccup_supervisor sup_checker #(.LATCH_CYC(LATCH_CYC)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_below_off (vcc_below_off),
    .vcc_below_inh (vcc_below_inh),
    .latch_pin     (latch_pin),
    .hv_src_en     (hv_src_en),
    .hv_src_hi     (hv_src_hi),
    .drive_en      (drive_en),
    .softstart_req (softstart_req)
);

// File: tb/hiccup_supervisor_tb_top.sv
`timescale 1ns/1ps
module hiccup_supervisor_tb_top;
    localparam int FB_N    = 20;  // 1 MHz clock setting, 20 us window
    localparam int LATCH_N = 5;   // 5000 ns filter at 1 MHz setting
    localparam int ROUNDS  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   vcc_mv = 0;
    logic fb_open = 1'b0;
    logic latch_pin = 1'b0;

    logic above_on, below_off, below_low, below_rst, below_inh;
    logic hv_src_en, hv_src_hi, drive_en, softstart_req;

    assign above_on  = (vcc_mv >= 12600);
    assign below_off = (vcc_mv < 9100);
    assign below_low = (vcc_mv < 5800);
    assign below_rst = (vcc_mv < 4000);
    assign below_inh = (vcc_mv < 600);

    always #4 clk = ~clk;

    hiccup_supervisor #(
        .CLK_KHZ(1000), .FB_OPEN_US(FB_N), .LATCH_FILT_NS(LATCH_N * 1000),
        .HICCUP_ROUNDS(ROUNDS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_on(above_on), .vcc_below_off(below_off),
        .vcc_below_low(below_low), .vcc_below_rst(below_rst),
        .vcc_below_inh(below_inh), .fb_open(fb_open), .latch_pin(latch_pin),
        .hv_src_en(hv_src_en), .hv_src_hi(hv_src_hi),
        .drive_en(drive_en), .softstart_req(softstart_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string phase = "R1";

    // Behavioural reference: mode names as strings, plain integer counters.
    string m_mode = "charge";
    int m_fb_seen = 0;
    int m_lp_seen = 0;
    int m_refills = 0;

    function automatic bit m_latched(string m);
        return (m == "lat_drain") || (m == "lat_fill");
    endfunction

    always @(posedge clk) begin
        string nxt;
        bool_blk: begin
            bit fb_expired, lp_expired, drv;
            if (!rst_n) begin
                m_mode = "charge"; m_fb_seen = 0; m_lp_seen = 0; m_refills = 0;
            end else begin
                drv = (m_mode == "launch") || (m_mode == "run");
                fb_expired = (m_fb_seen >= FB_N);
                lp_expired = (m_lp_seen >= LATCH_N);
                nxt = m_mode;
                if (lp_expired && !m_latched(m_mode)) nxt = "lat_drain";
                else if (m_latched(m_mode) && below_rst) nxt = "charge";
                else if (m_mode == "charge" && above_on) nxt = "launch";
                else if (drv) begin
                    if (fb_expired || below_off) begin nxt = "hic_drain"; m_refills = 0; end
                    else nxt = "run";
                end
                else if (m_mode == "hic_drain" && below_low) nxt = "hic_fill";
                else if (m_mode == "hic_fill" && above_on) begin
                    m_refills++;
                    if (m_refills >= ROUNDS) begin nxt = "launch"; m_refills = 0; end
                    else nxt = "hic_drain";
                end
                else if (m_mode == "lat_drain" && below_low) nxt = "lat_fill";
                else if (m_mode == "lat_fill" && above_on) nxt = "lat_drain";
                m_fb_seen = (fb_open && drv) ? m_fb_seen + 1 : 0;
                m_lp_seen = latch_pin ? m_lp_seen + 1 : 0;
                m_mode = nxt;
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_src, e_drv, e_ss;
            e_src = (m_mode == "charge") || (m_mode == "hic_fill") || (m_mode == "lat_fill");
            e_drv = (m_mode == "launch") || (m_mode == "run");
            e_ss  = (m_mode == "launch");
            chk(phase, hv_src_en, e_src, "model hv_src_en");
            chk(phase, hv_src_hi, e_src && !(vcc_mv < 600), "model hv_src_hi");
            chk(phase, drive_en, e_drv, "model drive_en");
            chk(phase, softstart_req, e_ss, "model softstart_req");
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic expect_out(string tag, logic src, logic drv, logic ss);
        #1;
        chk(tag, hv_src_en, src, "hv_src_en");
        chk(tag, drive_en, drv, "drive_en");
        chk(tag, softstart_req, ss, "softstart_req");
    endtask

    task automatic hiccup_rounds(int n);
        for (int i = 0; i < n; i++) begin
            vcc_mv = 5000; tick(1);
            vcc_mv = 13000; tick(1);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #1;
        phase = "R1";
        expect_out("R1", 1'b1, 1'b0, 1'b0);
        chk("R2", hv_src_hi, 1'b0, "low current below inhibit");

        phase = "R2";
        vcc_mv = 2000; tick(1); #1;
        chk("R2", hv_src_hi, 1'b1, "high current above inhibit");

        phase = "R3";
        vcc_mv = 13000; tick(1);
        expect_out("R3", 1'b0, 1'b1, 1'b1);
        tick(1);
        expect_out("R3", 1'b0, 1'b1, 1'b0);

        phase = "R4";
        fb_open = 1'b1; tick(FB_N - 1);
        fb_open = 1'b0; tick(3);
        expect_out("R4", 1'b0, 1'b1, 1'b0);
        fb_open = 1'b1; tick(FB_N);
        expect_out("R4", 1'b0, 1'b1, 1'b0);
        tick(1);
        expect_out("R4", 1'b0, 1'b0, 1'b0);
        fb_open = 1'b0;

        phase = "R6";
        tick(2);
        expect_out("R6", 1'b0, 1'b0, 1'b0);
        vcc_mv = 5000; tick(1);
        expect_out("R6", 1'b1, 1'b0, 1'b0);
        vcc_mv = 13000; tick(1);
        expect_out("R6", 1'b0, 1'b0, 1'b0);
        vcc_mv = 5000; tick(1);
        vcc_mv = 13000; tick(1);
        expect_out("R6", 1'b0, 1'b1, 1'b1);
        tick(1);

        phase = "R5";
        vcc_mv = 9000; tick(1);
        expect_out("R5", 1'b0, 1'b0, 1'b0);
        hiccup_rounds(ROUNDS);
        expect_out("R5", 1'b0, 1'b1, 1'b1);
        tick(2);

        phase = "R7";
        latch_pin = 1'b1; tick(LATCH_N - 1);
        latch_pin = 1'b0; tick(2);
        expect_out("R7", 1'b0, 1'b1, 1'b0);
        latch_pin = 1'b1; tick(LATCH_N);
        expect_out("R7", 1'b0, 1'b1, 1'b0);
        vcc_mv = 9000; tick(1);
        expect_out("R7", 1'b0, 1'b0, 1'b0);
        latch_pin = 1'b0;

        phase = "R8";
        for (int i = 0; i < 4; i++) begin
            vcc_mv = 5000; tick(1);
            expect_out("R8", 1'b1, 1'b0, 1'b0);
            vcc_mv = 13000; tick(1);
            expect_out("R8", 1'b0, 1'b0, 1'b0);
        end

        phase = "R9";
        vcc_mv = 3000; tick(1);
        expect_out("R9", 1'b1, 1'b0, 1'b0);
        chk("R9", hv_src_hi, 1'b1, "high current after release");
        vcc_mv = 13000; tick(1);
        expect_out("R9", 1'b0, 1'b1, 1'b1);
        tick(1);

        phase = "R7";
        vcc_mv = 9000; tick(1);
        expect_out("R7", 1'b0, 1'b0, 1'b0);
        latch_pin = 1'b1; tick(LATCH_N + 1);
        latch_pin = 1'b0;
        hiccup_rounds(ROUNDS + 1);
        expect_out("R7", 1'b0, 1'b0, 1'b0);

        phase = "R9";
        vcc_mv = 3000; tick(1);
        vcc_mv = 13000; tick(1);
        expect_out("R9", 1'b0, 1'b1, 1'b1);
        tick(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule